// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block sends one character at a time on an asynchronous serial line. A client puts a character on `char_data` and raises `char_valid`. The block takes it when `char_ready` is high. It then drives a frame on `line_out`:

- a space-level start bit;
- seven or eight data bits, least significant first;
- an optional parity bit;
- a mark-level stop interval of one, one and a half, or two bit times.

All frame timing comes from `half_tick`, a one-cycle pulse that arrives twice per bit time. A bit therefore spans two pulses, and a stop interval of 1.5 bits spans three. The data length, parity mode and stop length are captured together with the character, and they stay fixed until the frame ends. When eight data bits are selected, the parity setting is ignored.

A single state machine sequences the frame through six named states:

| State | What it does |
|---|---|
| IDLE | Line at mark, ready high. It moves to ARM when a character is accepted. |
| ARM | Line still at mark. It waits for the next `half_tick` so that the start bit begins on the tick grid, then moves to START. |
| START | Holds the line at space for one bit time, then moves to DATA. |
| DATA | Sends one bit per bit time. After the last data bit it goes to PARITY when parity is in effect, and to STOP otherwise. |
| PARITY | Sends the parity bit for one bit time, then moves to STOP. |
| STOP | Holds the line at mark for the chosen stop length, then returns to IDLE. |

Top module: `async_char_tx`

## Requirements
- R1: After reset and between frames, `line_out` is 1 (mark), `busy` is 0 and `char_ready` is 1.
- R2: A character is accepted on a rising clock edge where `char_valid` and `char_ready` are both 1. From the next cycle `busy` is 1 and `char_ready` is 0 until the frame ends. The line stays at mark until the first `half_tick` after acceptance.
- R3: The start bit is 0 and lasts exactly two `half_tick` periods.
- R4: With `cfg_eight_bits`=0, seven data bits `char_data[6:0]` follow the start bit. With `cfg_eight_bits`=1, eight bits `char_data[7:0]` follow it. In both cases the least significant bit goes first and each bit lasts two `half_tick` periods.
- R5: `cfg_parity` encodings are 0 none, 1 always 0, 2 always 1, 3 odd, 4 even; the values 5 to 7 act as none. A parity bit, when present, follows the data and lasts two `half_tick` periods.
- R6: Odd (even) parity makes the number of ones across `char_data[6:0]` and the parity bit odd (even).
- R7: With `cfg_eight_bits`=1 no parity bit is sent, whatever `cfg_parity` holds.
- R8: The stop interval is at mark and lasts 2 `half_tick` periods for `cfg_stop`=0, 3 for 1, and 4 for 2 or 3. In the cycle after the `half_tick` that ends it, `busy` is 0 and `char_ready` is 1.
- R9: Data and configuration are sampled at acceptance. Changes to `char_data`, `cfg_eight_bits`, `cfg_parity` or `cfg_stop` during a frame have no effect on that frame.
- R10: `line_out` changes only on the clock edge that follows a cycle in which `half_tick` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | One-cycle pulse at twice the bit rate |
| char_data | input | 8 | Character to send |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Block can take a character |
| cfg_eight_bits | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_parity | input | 3 | Parity mode, encoded as in R5 |
| cfg_stop | input | 2 | Stop length, encoded as in R8 |
| line_out | output | 1 | Serial line, 1 = mark |
| busy | output | 1 | A frame is in progress |

## Verification
After an accepted handshake, `busy` and `char_ready` change one clock later. The line leaves mark on the edge after the next `half_tick`. After that, every line level holds for a whole number of `half_tick` periods. The bench therefore reads the handshake flags on the falling edge after acceptance. It reads the line once per half-bit slot, on the falling edge inside each cycle where `half_tick` is high, so each sample is the level just before the edge that can change it. The end of the stop interval is checked on the falling edge one cycle after its final tick, where R8 puts the return to idle.

// File: rtl/tx_pkg.sv
`timescale 1ns/1ps
package tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ZERO = 3'd1,
        PAR_ONE  = 3'd2,
        PAR_ODD  = 3'd3,
        PAR_EVEN = 3'd4
    } parity_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_e;

endpackage

// File: rtl/tx_slot_timer.sv
`timescale 1ns/1ps
module tx_slot_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             slot_end
);

    logic [CNT_W-1:0] cnt_q;

    assign slot_end = tick && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || slot_end) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tx_frame_latch.sv
`timescale 1ns/1ps
module tx_frame_latch
    import tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SHORT_W       = 7,
    parameter int TICKS_PER_BIT = 2,
    parameter int CNT_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cfg_long,
    input  logic [2:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    output logic              cur_bit,
    output logic              par_bit,
    output logic              par_en,
    output logic              last_bit,
    output logic [CNT_W-1:0]  stop_limit
);

    localparam int IDX_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int LIM_ONE   = TICKS_PER_BIT - 1;
    localparam int LIM_HALF  = TICKS_PER_BIT + (TICKS_PER_BIT / 2) - 1;
    localparam int LIM_TWO   = 2 * TICKS_PER_BIT - 1;

    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              long_q;
    logic              par_bit_q;
    logic              par_en_q;
    logic [CNT_W-1:0]  stop_limit_q;

    logic              par_bit_d;
    logic              par_en_d;
    logic [CNT_W-1:0]  stop_limit_d;
    logic              short_xor;

    assign short_xor = ^data_in[SHORT_W-1:0];

    always_comb begin
        par_en_d  = 1'b0;
        par_bit_d = 1'b0;
        if (!cfg_long) begin
            unique case (parity_e'(cfg_parity))
                PAR_ZERO: begin par_en_d = 1'b1; par_bit_d = 1'b0;       end
                PAR_ONE:  begin par_en_d = 1'b1; par_bit_d = 1'b1;       end
                PAR_ODD:  begin par_en_d = 1'b1; par_bit_d = ~short_xor; end
                PAR_EVEN: begin par_en_d = 1'b1; par_bit_d = short_xor;  end
                default:  begin par_en_d = 1'b0; par_bit_d = 1'b0;       end
            endcase
        end
    end

    always_comb begin
        unique case (stop_e'(cfg_stop))
            STOP_ONE:      stop_limit_d = CNT_W'(LIM_ONE);
            STOP_ONE_HALF: stop_limit_d = CNT_W'(LIM_HALF);
            default:       stop_limit_d = CNT_W'(LIM_TWO);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q      <= '1;
            idx_q        <= '0;
            long_q       <= 1'b0;
            par_bit_q    <= 1'b0;
            par_en_q     <= 1'b0;
            stop_limit_q <= CNT_W'(LIM_ONE);
        end else if (load) begin
            shreg_q      <= data_in;
            idx_q        <= '0;
            long_q       <= cfg_long;
            par_bit_q    <= par_bit_d;
            par_en_q     <= par_en_d;
            stop_limit_q <= stop_limit_d;
        end else if (shift) begin
            shreg_q      <= {1'b1, shreg_q[DATA_W-1:1]};
            idx_q        <= idx_q + 1'b1;
        end
    end

    assign cur_bit    = shreg_q[0];
    assign par_bit    = par_bit_q;
    assign par_en     = par_en_q;
    assign stop_limit = stop_limit_q;
    assign last_bit   = long_q ? (idx_q == IDX_W'(DATA_W - 1))
                               : (idx_q == IDX_W'(SHORT_W - 1));

endmodule

// File: rtl/async_char_tx.sv
`timescale 1ns/1ps
module async_char_tx
    import tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SHORT_W       = 7,
    parameter int TICKS_PER_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_valid,
    output logic              char_ready,
    input  logic              cfg_eight_bits,
    input  logic [2:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    output logic              line_out,
    output logic              busy
);

    localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT);
    localparam int BIT_LAST = TICKS_PER_BIT - 1;

    tx_state_e        state_q, state_d;
    logic             accept;
    logic             in_slot;
    logic             slot_end;
    logic             timer_clr;
    logic [CNT_W-1:0] slot_limit;
    logic             cur_bit, par_bit, par_en, last_bit;
    logic [CNT_W-1:0] stop_limit;

    assign accept    = char_valid && (state_q == ST_IDLE);
    assign in_slot   = (state_q == ST_START) || (state_q == ST_DATA) ||
                       (state_q == ST_PARITY) || (state_q == ST_STOP);
    assign timer_clr = !in_slot;
    assign slot_limit = (state_q == ST_STOP) ? stop_limit : CNT_W'(BIT_LAST);

    tx_slot_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .tick     (half_tick && in_slot),
        .limit    (slot_limit),
        .slot_end (slot_end)
    );

    tx_frame_latch #(
        .DATA_W        (DATA_W),
        .SHORT_W       (SHORT_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CNT_W         (CNT_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .shift      (slot_end && (state_q == ST_DATA)),
        .data_in    (char_data),
        .cfg_long   (cfg_eight_bits),
        .cfg_parity (cfg_parity),
        .cfg_stop   (cfg_stop),
        .cur_bit    (cur_bit),
        .par_bit    (par_bit),
        .par_en     (par_en),
        .last_bit   (last_bit),
        .stop_limit (stop_limit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_ARM;
            ST_ARM:    if (half_tick) state_d = ST_START;
            ST_START:  if (slot_end)  state_d = ST_DATA;
            ST_DATA:   if (slot_end && last_bit)
                           state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (slot_end)  state_d = ST_STOP;
            ST_STOP:   if (slot_end)  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        line_out   = 1'b1;
        busy       = 1'b1;
        char_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; char_ready = 1'b1; end
            ST_ARM:    line_out = 1'b1;
            ST_START:  line_out = 1'b0;
            ST_DATA:   line_out = cur_bit;
            ST_PARITY: line_out = par_bit;
            ST_STOP:   line_out = 1'b1;
            default:   begin busy = 1'b0; char_ready = 1'b0; end
        endcase
    end

endmodule

// File: rtl/async_char_tx_chk.sv
`timescale 1ns/1ps
module async_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic char_valid,
    input logic char_ready,
    input logic busy,
    input logic line_out
);

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R2
    ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_ready |-> !busy);

    // R2
    accept_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_ready) |=> (busy && !char_ready && line_out));

    // R2
    busy_by_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(char_valid));

    // R10
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_out) |-> $past(half_tick));

    // R8
    idle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(half_tick));

endmodule

bind async_char_tx async_char_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .char_valid (char_valid),
    .char_ready (char_ready),
    .busy       (busy),
    .line_out   (line_out)
);

// File: tb/async_char_tx_bench.sv
`timescale 1ns/1ps
module async_char_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_valid = 1'b0;
    logic       char_ready;
    logic       cfg_eight_bits = 1'b0;
    logic [2:0] cfg_parity = '0;
    logic [1:0] cfg_stop = '0;
    logic       line_out;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    async_char_tx u_async_char_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .half_tick      (half_tick),
        .char_data      (char_data),
        .char_valid     (char_valid),
        .char_ready     (char_ready),
        .cfg_eight_bits (cfg_eight_bits),
        .cfg_parity     (cfg_parity),
        .cfg_stop       (cfg_stop),
        .line_out       (line_out),
        .busy           (busy)
    );

    // half-bit pulse: one cycle in four, changed 2 ns after the rising edge
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            half_tick = (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected half-bit slot levels, slot 0 first in bit 0
    task automatic build_frame(input logic [7:0] d, input logic eight,
                               input logic [2:0] par, input logic [1:0] stp,
                               output logic [31:0] exp_v, output int n);
        int ones = 0;
        int nbits = eight ? 8 : 7;
        int mode = (eight || par > 3'd4) ? 0 : int'(par);
        logic pb = 1'b0;
        int stop_slots = (stp == 2'd0) ? 2 : (stp == 2'd1) ? 3 : 4;
        exp_v = '1;
        n = 0;
        exp_v[n] = 1'b0; n++;
        exp_v[n] = 1'b0; n++;
        for (int i = 0; i < nbits; i++) begin
            exp_v[n] = d[i]; n++;
            exp_v[n] = d[i]; n++;
        end
        for (int i = 0; i < 7; i++) ones += int'(d[i]);
        if (mode != 0) begin
            if (mode == 1) pb = 1'b0;
            else if (mode == 2) pb = 1'b1;
            else if (mode == 3) pb = (ones % 2 == 0);
            else pb = (ones % 2 == 1);
            exp_v[n] = pb; n++;
            exp_v[n] = pb; n++;
        end
        for (int i = 0; i < stop_slots; i++) begin
            exp_v[n] = 1'b1; n++;
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic eight,
                             input logic [2:0] par, input logic [1:0] stp,
                             input string req);
        logic [31:0] exp_v;
        logic [31:0] got_v;
        int n;
        int guard;
        build_frame(d, eight, par, stp, exp_v, n);
        @(negedge clk);
        char_data = d; cfg_eight_bits = eight; cfg_parity = par; cfg_stop = stp;
        char_valid = 1'b1;
        check(char_ready == 1'b1, "R1", "ready before frame", char_ready, 1);
        @(negedge clk);
        char_valid = 1'b0;
        // R9: scramble every input right after acceptance
        char_data = ~d; cfg_eight_bits = ~eight;
        cfg_parity = par + 3'd1; cfg_stop = stp + 2'd1;
        check(busy && !char_ready && line_out, "R2", "flags after accept",
              {busy, char_ready, line_out}, 3'b101);
        guard = 0;
        while (line_out !== 1'b0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 100, "R2", "start bit begins", guard, 0);
        got_v = '1;
        // each sample sits in a half_tick cycle, so it spans one slot (R10)
        for (int s = 0; s < n; s++) begin
            do @(negedge clk); while (!half_tick);
            got_v[s] = line_out;
        end
        check(got_v == exp_v, {req, " R3 R9"}, "frame slots", got_v, exp_v);
        @(negedge clk);
        check(!busy && char_ready && line_out, "R8", "idle after stop",
              {busy, char_ready, line_out}, 3'b011);
    endtask

    task automatic test_reset();
        check(line_out && !busy && char_ready, "R1", "reset state",
              {line_out, busy, char_ready}, 3'b101);
    endtask

    task automatic test_data_lengths();
        run_frame(8'h55, 1'b0, 3'd0, 2'd0, "R4 seven");
        run_frame(8'hA3, 1'b1, 3'd0, 2'd2, "R4 eight");
        run_frame(8'h8B, 1'b0, 3'd0, 2'd0, "R4 seven top ignored");
    endtask

    task automatic test_forced_parity();
        run_frame(8'h7F, 1'b0, 3'd1, 2'd0, "R5 zero");
        run_frame(8'h00, 1'b0, 3'd2, 2'd0, "R5 one");
        run_frame(8'h2A, 1'b0, 3'd6, 2'd0, "R5 reserved none");
    endtask

    task automatic test_odd_even();
        run_frame(8'h00, 1'b0, 3'd3, 2'd0, "R6 odd zeros");
        run_frame(8'h00, 1'b0, 3'd4, 2'd0, "R6 even zeros");
        run_frame(8'h8B, 1'b0, 3'd3, 2'd0, "R6 odd three");
        run_frame(8'h0B, 1'b0, 3'd4, 2'd1, "R6 even three");
    endtask

    task automatic test_eight_no_parity();
        run_frame(8'hC1, 1'b1, 3'd3, 2'd0, "R7 odd dropped");
        run_frame(8'h3C, 1'b1, 3'd2, 2'd0, "R7 one dropped");
    endtask

    task automatic test_stop_lengths();
        run_frame(8'h12, 1'b0, 3'd0, 2'd1, "R8 one and half");
        run_frame(8'h34, 1'b0, 3'd4, 2'd3, "R8 two alt");
        run_frame(8'hF0, 1'b1, 3'd0, 2'd1, "R8 eight one and half");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_data_lengths();
        test_forced_parity();
        test_odd_even();
        test_eight_no_parity();
        test_stop_lengths();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule